// File: doc/BRIEF.md
# Six-State Self-Correcting Sequence Counter

This block is a 3-bit synchronous state counter whose bits are named A (most significant), B and C. On each rising clock edge it moves through a repeating cycle of six codes: the low pair B,C runs 00, 01, 10, and A changes value once in every three steps. Codes 011 and 111 belong to no step of the cycle. Each bit is a JK-style storage element. Its J and K inputs come from fixed equations on the current state.

The two unused codes are handled on purpose. If the counter ever holds one of them, the same equations bring it back into the cycle on the next edge. A synchronous, active-high reset loads a start code. That code is set by a parameter and defaults to 000. The three state bits are plain outputs. They serve as a divide-by-six phase indicator, or as a three-phase pattern together with a half-rate flag.

Top module: `seq6_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the state becomes the reset code (ABC = 000 by default) and stays there for as long as `rst` stays high. Reset acts only at the edge.
- R2: With `rst` low, each rising edge moves ABC through 000 → 001 → 010 → 100 → 101 → 110 → 000. The outputs are bit A on `cnt_a`, bit B on `cnt_b` and bit C on `cnt_c`.
- R3: Over the cycle, the pair B,C repeats 00, 01, 10. Bit A changes exactly once every three edges, so the full period is six edges.
- R4: From ABC = 011, the next edge gives 100.
- R5: From ABC = 111, the next edge gives 000.
- R6: Each bit behaves as a JK element, with JK = 00 meaning hold, 01 meaning clear, 10 meaning set and 11 meaning toggle. The inputs are J_A = K_A = B, J_B = C with K_B = 1, and J_C = NOT B with K_C = 1.
- R7: Starting from any code of the six-step cycle, the counter never reaches 011 or 111.
- R8: The parameter `RESET_CODE` sets the code loaded by reset. This includes the unused codes 011 and 111, and the counter recovers from them as stated in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to `RESET_CODE` |
| cnt_a | output | 1 | State bit A (most significant) |
| cnt_b | output | 1 | State bit B |
| cnt_c | output | 1 | State bit C (least significant) |

## Verification
The counter has no load input, and its legal cycle never passes through 011 or 111. The recovery paths therefore cannot be reached from the ports of a normally configured instance. The bench handles this by building two extra copies with `RESET_CODE` set to 011 and to 111. A reset places each copy in an unused code, and the bench then checks the first step out, as well as the cycle that follows. A reset applied in the middle of the count also returns those copies to their unused codes, so recovery is checked a second time from a running state.

// File: rtl/seq6_pkg.sv
`timescale 1ns/1ps
package seq6_pkg;
  localparam int CODE_W = 3;
  localparam int BIT_A  = 2;
  localparam int BIT_B  = 1;
  localparam int BIT_C  = 0;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic j;
    logic k;
  } jk_t;

  // Cycle successor written as a table, independent of the JK equations.
  function automatic code_t cycle_succ(input code_t cur);
    case (cur)
      3'b000:  cycle_succ = 3'b001;
      3'b001:  cycle_succ = 3'b010;
      3'b010:  cycle_succ = 3'b100;
      3'b100:  cycle_succ = 3'b101;
      3'b101:  cycle_succ = 3'b110;
      3'b110:  cycle_succ = 3'b000;
      3'b011:  cycle_succ = 3'b100;
      default: cycle_succ = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/seq6_excite.sv
`timescale 1ns/1ps
module seq6_excite
  import seq6_pkg::*;
(
  input  code_t                  cur,
  output jk_t   [CODE_W-1:0]     drv
);
  // R6: excitation equations
  always_comb begin
    drv[BIT_A].j = cur[BIT_B];
    drv[BIT_A].k = cur[BIT_B];
    drv[BIT_B].j = cur[BIT_C];
    drv[BIT_B].k = 1'b1;
    drv[BIT_C].j = ~cur[BIT_B];
    drv[BIT_C].k = 1'b1;
  end
endmodule

// File: rtl/seq6_jkbit.sv
`timescale 1ns/1ps
module seq6_jkbit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case ({j, k})
        2'b00: q <= q;
        2'b01: q <= 1'b0;
        2'b10: q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end

  assert_jk_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!j && !k) |=> (q == $past(q)));
  assert_jk_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!j && k) |=> (q == 1'b0));
  assert_jk_set_R6: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> (q == 1'b1));
  assert_jk_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (j && k) |=> (q != $past(q)));
endmodule

// File: rtl/seq6_counter.sv
`timescale 1ns/1ps
module seq6_counter
  import seq6_pkg::*;
#(
  parameter code_t RESET_CODE = 3'b000
) (
  input  logic clk,
  input  logic rst,
  output logic cnt_a,
  output logic cnt_b,
  output logic cnt_c
);
  code_t                 state;
  jk_t   [CODE_W-1:0]    drv;

  seq6_excite u_excite (
    .cur (state),
    .drv (drv)
  );

  for (genvar gi = 0; gi < CODE_W; gi++) begin : g_bit
    seq6_jkbit #(
      .RST_VAL (RESET_CODE[gi])
    ) u_bit (
      .clk (clk),
      .rst (rst),
      .j   (drv[gi].j),
      .k   (drv[gi].k),
      .q   (state[gi])
    );
  end

  assign cnt_a = state[BIT_A];
  assign cnt_b = state[BIT_B];
  assign cnt_c = state[BIT_C];

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (state == RESET_CODE));
  assert_cycle_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (state == cycle_succ($past(state))));
  assert_recover_011_R4: assert property (@(posedge clk) disable iff (rst)
    (state == 3'b011) |=> (state == 3'b100));
  assert_recover_111_R5: assert property (@(posedge clk) disable iff (rst)
    (state == 3'b111) |=> (state == 3'b000));
  assert_no_unused_entry_R7: assert property (@(posedge clk) disable iff (rst)
    !(state[BIT_B] && state[BIT_C]) |=> !(state[BIT_B] && state[BIT_C]));
endmodule

// File: tb/tb_seq6_counter.sv
`timescale 1ns/1ps
module tb_seq6_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_a, m_b, m_c;
  logic s3_a, s3_b, s3_c;
  logic s7_a, s7_b, s7_c;
  int   n_total = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #5 clk = ~clk;

  seq6_counter dut (.clk(clk), .rst(rst), .cnt_a(m_a), .cnt_b(m_b), .cnt_c(m_c));
  seq6_counter #(.RESET_CODE(3'b011)) dut_s3 (.clk(clk), .rst(rst),
    .cnt_a(s3_a), .cnt_b(s3_b), .cnt_c(s3_c));
  seq6_counter #(.RESET_CODE(3'b111)) dut_s7 (.clk(clk), .rst(rst),
    .cnt_a(s7_a), .cnt_b(s7_b), .cnt_c(s7_c));

  // Each entry: {main, seeded 011, seeded 111} after step i+1.
  localparam logic [8:0] VEC [12] = '{
    {3'b001, 3'b100, 3'b000}, {3'b010, 3'b101, 3'b001},
    {3'b100, 3'b110, 3'b010}, {3'b101, 3'b000, 3'b100},
    {3'b110, 3'b001, 3'b101}, {3'b000, 3'b010, 3'b110},
    {3'b001, 3'b100, 3'b000}, {3'b010, 3'b101, 3'b001},
    {3'b100, 3'b110, 3'b010}, {3'b101, 3'b000, 3'b100},
    {3'b110, 3'b001, 3'b101}, {3'b000, 3'b010, 3'b110}
  };

  task automatic check(input logic [2:0] got, input logic [2:0] exp, input string tag);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    int a_flips;
    bit bc_bad;
    logic prev_a;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({m_a, m_b, m_c}, 3'b000, "R1 reset state main");
    check({s3_a, s3_b, s3_c}, 3'b011, "R8 reset code 011");
    check({s7_a, s7_b, s7_c}, 3'b111, "R8 reset code 111");
    rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check({m_a, m_b, m_c}, VEC[i][8:6], $sformatf("R2 R6 cycle step %0d", i));
      check({s3_a, s3_b, s3_c}, VEC[i][5:3],
            (i == 0) ? "R4 exit from 011" : $sformatf("R4 R8 after 011 step %0d", i));
      check({s7_a, s7_b, s7_c}, VEC[i][2:0],
            (i == 0) ? "R5 exit from 111" : $sformatf("R5 R8 after 111 step %0d", i));
    end
    // R3 and R7: long run, count A changes and look for BC = 11
    a_flips = 0;
    bc_bad  = 1'b0;
    prev_a  = m_a;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      if (m_a != prev_a) a_flips++;
      prev_a = m_a;
      if ((m_b && m_c) || (s3_b && s3_c) || (s7_b && s7_c)) bc_bad = 1'b1;
    end
    check(3'(a_flips), 3'd4, "R3 A changes in 36 steps div 3");
    n_total++;
    if (a_flips != 12) begin
      n_fail++;
      $display("FAIL R3: A flips got %0d expected %0d", a_flips, 12);
    end
    check({2'b00, bc_bad}, 3'b000, "R7 unused code entered");
    // mid-count reset: advance two steps first (000 -> 001 -> 010)
    repeat (2) @(negedge clk);
    check({m_a, m_b, m_c}, 3'b010, "R2 position before reset");
    rst = 1'b1;
    #1;
    check({m_a, m_b, m_c}, 3'b010, "R1 reset waits for edge");
    @(negedge clk);
    check({m_a, m_b, m_c}, 3'b000, "R1 mid-count reset");
    check({s3_a, s3_b, s3_c}, 3'b011, "R8 mid-count reset 011");
    check({s7_a, s7_b, s7_c}, 3'b111, "R8 mid-count reset 111");
    @(negedge clk);
    check({m_a, m_b, m_c}, 3'b000, "R1 reset held");
    rst = 1'b0;
    @(negedge clk);
    check({m_a, m_b, m_c}, 3'b001, "R2 first step after reset");
    check({s3_a, s3_b, s3_c}, 3'b100, "R4 second exit from 011");
    check({s7_a, s7_b, s7_c}, 3'b000, "R5 second exit from 111");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule